// File: doc/BRIEF.md
# Operand Criticality Predictor and Wire Steering

A clustered out-of-order core moves values between clusters on two kinds of wire. Fast wires have low delay and high power. Slow wires save power but add delay. This block picks one of the two for every transfer, combinationally, in the cycle the transfer is presented.

The transfer kind settles the route for most traffic. Values not needed at once (ready registers, store data, addresses sent only to confirm an address prediction) go slow. Values that gate execution (load data, unpredicted addresses) go fast. Bypassed register values consult a per-instruction predictor. The predictor is a table of 2-bit saturating counters indexed by instruction-address bits [9:2].

Each counter is trained from a measured slack: the consumer's issue cycle minus the operand's arrival cycle at that cluster. A slack at or under the programmable threshold counts as a critical outcome; a larger slack counts as non-critical. Undefined kind codes fall back to fast wires so that unknown traffic never pays the delay penalty.

Top module: `crit_wire_steer`

## Requirements
- R1: After reset, every table entry is weakly critical (counter value 2), so a bypassed value (kind 0) from any PC is routed fast (`fast_sel_o` = 1).
- R2: The table entry is selected by PC bits [9:2] only. Two PCs that agree in those bits share one entry for both lookup and training, and PCs that differ there do not.
- R3: A training slack (`train_issue_i` − `train_arrive_i`) less than or equal to `crit_thresh_i` is a critical outcome and increments the entry. The threshold is taken from the port in the training cycle.
- R4: A training slack greater than `crit_thresh_i` is a non-critical outcome and decrements the entry.
- R5: The counter saturates at 3. A bypassed lookup is fast when the counter is 2 or 3. Two consecutive critical outcomes on one entry always make it predict fast.
- R6: The counter saturates at 0. A bypassed lookup is slow when the counter is 0 or 1. Two consecutive non-critical outcomes on one entry always make it predict slow.
- R7: The following kinds are always routed slow (`fast_sel_o` = 0), whatever the prediction: ready register value (kind 1), address sent to verify a prediction (kind 3) and store value (kind 4).
- R8: The following kinds are always routed fast: unpredicted effective address (kind 2), load value (kind 5) and the undefined codes 6 and 7.
- R9: A training write takes effect at the next rising clock edge. A lookup of the same entry in the training cycle returns the old prediction.
- R10: When the issue cycle is not later than the arrival cycle, the slack is taken as 0. Such an outcome is therefore critical for any threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| xfer_kind_i | input | 3 | Transfer kind code of the current transfer |
| xfer_pc_i | input | PC_W (32) | Instruction address of the current transfer |
| train_valid_i | input | 1 | Training sample present this cycle |
| train_pc_i | input | PC_W (32) | Instruction address of the trained consumer |
| train_arrive_i | input | CYC_W (16) | Cycle the operand reached the consumer cluster |
| train_issue_i | input | CYC_W (16) | Cycle the consumer issued |
| crit_thresh_i | input | CYC_W (16) | Slack threshold for a critical outcome |
| fast_sel_o | output | 1 | 1 routes the transfer on fast wires, 0 on slow wires |

## Verification
The bench goes after four corner cases:
- **Slack equal to the threshold.** A strict comparison would count it non-critical and send the next bypass slow.
- **Issue before arrival.** A design without the clamp would wrap the subtraction into a huge slack and mark the entry non-critical.
- **Saturation at both ends of the counter.** A wrapping counter would flip 3 to 0 or 0 to 3 and invert the route after long runs of one outcome.
- **Same-cycle train and lookup, and aliasing.** A read-through table would return the new value early. Indexing with the wrong PC bits would make aliased PCs disagree or make unrelated PCs interfere.

// File: rtl/crit_steer_pkg.sv
package crit_steer_pkg;
  typedef enum logic [2:0] {
    XK_BYPASS     = 3'd0,
    XK_READY      = 3'd1,
    XK_ADDR_MISS  = 3'd2,
    XK_ADDR_CHECK = 3'd3,
    XK_STORE      = 3'd4,
    XK_LOAD       = 3'd5
  } xfer_kind_e;

  typedef enum logic [1:0] {
    RT_PRED = 2'd0,
    RT_FAST = 2'd1,
    RT_SLOW = 2'd2
  } route_src_e;

  function automatic route_src_e kind_route(logic [2:0] kind);
    case (kind)
      XK_BYPASS:     return RT_PRED;
      XK_READY:      return RT_SLOW;
      XK_ADDR_CHECK: return RT_SLOW;
      XK_STORE:      return RT_SLOW;
      default:       return RT_FAST;
    endcase
  endfunction
endpackage

// File: rtl/crit_slack_cls.sv
module crit_slack_cls #(
  parameter int CYC_W = 16
) (
  input  logic [CYC_W-1:0] arrive_i,
  input  logic [CYC_W-1:0] issue_i,
  input  logic [CYC_W-1:0] thresh_i,
  output logic             crit_o
);
  logic [CYC_W-1:0] slack;

  // issue not after arrival: clamp to zero instead of wrapping
  always_comb begin
    if (issue_i > arrive_i) slack = issue_i - arrive_i;
    else                    slack = '0;
    crit_o = (slack <= thresh_i);
  end
endmodule

// File: rtl/crit_pred_table.sv
module crit_pred_table #(
  parameter int IDX_W     = 8,
  parameter int CTR_W     = 2,
  parameter int RESET_CTR = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_crit_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_crit_i
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CTR_MAX  = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'(RESET_CTR);

  logic [CTR_W-1:0] ctr_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic hit;
    assign hit = wr_en_i && (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctr_q[g] <= CTR_INIT;
      end else if (hit) begin
        if (wr_crit_i) begin
          if (ctr_q[g] != CTR_MAX) ctr_q[g] <= ctr_q[g] + 1'b1;
        end else begin
          if (ctr_q[g] != '0) ctr_q[g] <= ctr_q[g] - 1'b1;
        end
      end
    end
  end

  // read sees pre-edge state, so same-cycle training is not visible
  assign rd_crit_o = ctr_q[rd_idx_i][CTR_W-1];
endmodule

// File: rtl/crit_route_sel.sv
module crit_route_sel
  import crit_steer_pkg::*;
(
  input  logic [2:0] kind_i,
  input  logic       pred_crit_i,
  output logic       fast_o
);
  route_src_e src;

  always_comb begin
    src = kind_route(kind_i);
    unique case (src)
      RT_PRED: fast_o = pred_crit_i;
      RT_SLOW: fast_o = 1'b0;
      default: fast_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/crit_wire_steer.sv
module crit_wire_steer #(
  parameter int PC_W    = 32,
  parameter int IDX_LSB = 2,
  parameter int IDX_W   = 8,
  parameter int CYC_W   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       xfer_kind_i,
  input  logic [PC_W-1:0]  xfer_pc_i,
  input  logic             train_valid_i,
  input  logic [PC_W-1:0]  train_pc_i,
  input  logic [CYC_W-1:0] train_arrive_i,
  input  logic [CYC_W-1:0] train_issue_i,
  input  logic [CYC_W-1:0] crit_thresh_i,
  output logic             fast_sel_o
);
  localparam int IDX_MSB = IDX_LSB + IDX_W - 1;

  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic             pred_crit, train_crit;

  assign rd_idx = xfer_pc_i[IDX_MSB:IDX_LSB];
  assign wr_idx = train_pc_i[IDX_MSB:IDX_LSB];

  crit_slack_cls #(.CYC_W(CYC_W)) u_cls (
    .arrive_i (train_arrive_i),
    .issue_i  (train_issue_i),
    .thresh_i (crit_thresh_i),
    .crit_o   (train_crit)
  );

  crit_pred_table #(.IDX_W(IDX_W), .CTR_W(2), .RESET_CTR(2)) u_tbl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (rd_idx),
    .rd_crit_o (pred_crit),
    .wr_en_i   (train_valid_i),
    .wr_idx_i  (wr_idx),
    .wr_crit_i (train_crit)
  );

  crit_route_sel u_route (
    .kind_i      (xfer_kind_i),
    .pred_crit_i (pred_crit),
    .fast_o      (fast_sel_o)
  );
endmodule

// File: rtl/crit_wire_steer_chk.sv
module crit_wire_steer_chk #(
  parameter int PC_W    = 32,
  parameter int IDX_LSB = 2,
  parameter int IDX_W   = 8,
  parameter int CYC_W   = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       xfer_kind_i,
  input logic [PC_W-1:0]  xfer_pc_i,
  input logic             train_valid_i,
  input logic [PC_W-1:0]  train_pc_i,
  input logic [CYC_W-1:0] train_arrive_i,
  input logic [CYC_W-1:0] train_issue_i,
  input logic [CYC_W-1:0] crit_thresh_i,
  input logic             fast_sel_o
);
  localparam int IDX_MSB = IDX_LSB + IDX_W - 1;

  logic [1:0]       age_q;
  logic [IDX_W-1:0] t_idx, x_idx;
  logic             t_crit, t_good, t_bad;

  assign t_idx  = train_pc_i[IDX_MSB:IDX_LSB];
  assign x_idx  = xfer_pc_i[IDX_MSB:IDX_LSB];
  assign t_crit = (train_issue_i <= train_arrive_i) ||
                  ((train_issue_i - train_arrive_i) <= crit_thresh_i);
  assign t_good = train_valid_i && t_crit;
  assign t_bad  = train_valid_i && !t_crit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 1'b1;
  end

  assert_slow_kinds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_kind_i == 3'd1 || xfer_kind_i == 3'd3 || xfer_kind_i == 3'd4) |-> !fast_sel_o);

  assert_fast_kinds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_kind_i == 3'd2 || xfer_kind_i >= 3'd5) |-> fast_sel_o);

  assert_two_crit_fast_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2 && $past(t_good, 2) && $past(t_good, 1) &&
     $past(t_idx, 2) == $past(t_idx, 1) && $past(t_idx, 1) == x_idx &&
     xfer_kind_i == 3'd0) |-> fast_sel_o);

  assert_two_noncrit_slow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2 && $past(t_bad, 2) && $past(t_bad, 1) &&
     $past(t_idx, 2) == $past(t_idx, 1) && $past(t_idx, 1) == x_idx &&
     xfer_kind_i == 3'd0) |-> !fast_sel_o);
endmodule

bind crit_wire_steer crit_wire_steer_chk #(
  .PC_W(PC_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W), .CYC_W(CYC_W)
) u_chk (.*);

// File: tb/crit_wire_steer_bench.sv
module crit_wire_steer_bench;
  localparam int PC_W  = 32;
  localparam int CYC_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [2:0]       kind = '0;
  logic [PC_W-1:0]  pc = '0;
  logic             tv = 1'b0;
  logic [PC_W-1:0]  tpc = '0;
  logic [CYC_W-1:0] tarr = '0, tiss = '0, thr = '0;
  logic             fast;

  int checks = 0, fails = 0;
  bit done = 0;
  int model [256];

  always #2 clk = ~clk;

  crit_wire_steer u_crit_wire_steer (
    .clk_i(clk), .rst_ni(rst_n), .xfer_kind_i(kind), .xfer_pc_i(pc),
    .train_valid_i(tv), .train_pc_i(tpc), .train_arrive_i(tarr),
    .train_issue_i(tiss), .crit_thresh_i(thr), .fast_sel_o(fast)
  );

  function automatic int idx_of(logic [PC_W-1:0] p);
    return int'(p[9:2]);
  endfunction

  function automatic bit exp_crit(logic [CYC_W-1:0] a, logic [CYC_W-1:0] i,
                                  logic [CYC_W-1:0] t);
    if (i <= a) return 1'b1;
    return (i - a) <= t;
  endfunction

  function automatic bit exp_fast(logic [2:0] k, logic [PC_W-1:0] p);
    case (k)
      3'd0: return model[idx_of(p)] >= 2;
      3'd1, 3'd3, 3'd4: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(string req, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: fast_sel_o=%0b expected %0b (kind=%0d pc=%h)", req, act, exp, kind, pc);
    end
  endtask

  // drive one cycle; optional check before the edge; model updated at the edge
  task automatic step(logic [2:0] k, logic [PC_W-1:0] p, bit do_t,
                      logic [PC_W-1:0] tp, logic [CYC_W-1:0] a,
                      logic [CYC_W-1:0] i, logic [CYC_W-1:0] t,
                      bit do_chk, string req, bit exp);
    @(negedge clk);
    kind = k; pc = p; tv = do_t; tpc = tp; tarr = a; tiss = i; thr = t;
    #1;
    if (do_chk) check(req, fast, exp);
    @(posedge clk);
    if (do_t) begin
      int ix = idx_of(tp);
      if (exp_crit(a, i, t)) begin
        if (model[ix] < 3) model[ix]++;
      end else if (model[ix] > 0) model[ix]--;
    end
  endtask

  task automatic look(logic [2:0] k, logic [PC_W-1:0] p, string req, bit exp);
    step(k, p, 1'b0, '0, '0, '0, 16'd10, 1'b1, req, exp);
  endtask

  task automatic train(logic [PC_W-1:0] tp, logic [CYC_W-1:0] a,
                       logic [CYC_W-1:0] i, logic [CYC_W-1:0] t);
    step(3'd1, '0, 1'b1, tp, a, i, t, 1'b0, "", 1'b0);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [PC_W-1:0] pa, pb, pc_c;
    int unused_seed;
    for (int n = 0; n < 256; n++) model[n] = 2;
    unused_seed = $urandom(32'h5eed_1234);
    pa = 32'h0000_0100; pb = 32'h0000_0200; pc_c = 32'h0000_0304;

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state weakly critical
    look(3'd0, 32'h0000_0000, "R1", 1'b1);
    look(3'd0, 32'h0000_03fc, "R1", 1'b1);
    look(3'd0, 32'h1234_5678, "R1", 1'b1);

    // R4 + R9: noncrit training, same-cycle lookup sees old value
    step(3'd0, pa, 1'b1, pa, 16'd100, 16'd111, 16'd10, 1'b1, "R9", 1'b1);
    look(3'd0, pa, "R4", 1'b0);
    // R3: slack equal to threshold is critical
    train(pa, 16'd100, 16'd110, 16'd10);
    look(3'd0, pa, "R3", 1'b1);
    // R3: programmable threshold, slack 15 under threshold 20
    train(pa, 16'd100, 16'd111, 16'd10);
    look(3'd0, pa, "R4", 1'b0);
    train(pa, 16'd200, 16'd215, 16'd20);
    look(3'd0, pa, "R3", 1'b1);

    // R5: saturate at 3, one noncrit leaves it fast
    repeat (4) train(pa, 16'd5, 16'd6, 16'd10);
    train(pa, 16'd5, 16'd60, 16'd10);
    look(3'd0, pa, "R5", 1'b1);
    // R6: saturate at 0, one crit leaves it slow
    repeat (5) train(pa, 16'd5, 16'd60, 16'd10);
    train(pa, 16'd5, 16'd6, 16'd10);
    look(3'd0, pa, "R6", 1'b0);

    // R10: issue before arrival counts as slack 0
    train(pb, 16'd50, 16'd90, 16'd0);
    look(3'd0, pb, "R4", 1'b0);
    train(pb, 16'd50, 16'd40, 16'd0);
    look(3'd0, pb, "R10", 1'b1);

    // R2: aliasing on PC[9:2] only
    train(pc_c, 16'd0, 16'd99, 16'd3);
    look(3'd0, 32'h8000_0306, "R2", 1'b0);
    look(3'd0, 32'hffff_f704, "R2", 1'b0);
    look(3'd0, 32'h0000_0308, "R2", 1'b1);

    // R7: fixed slow kinds on an entry predicting fast
    look(3'd1, 32'h0, "R7", 1'b0);
    look(3'd3, 32'h0, "R7", 1'b0);
    look(3'd4, 32'h0, "R7", 1'b0);
    // R8: fixed fast kinds on an entry predicting slow
    look(3'd2, pc_c, "R8", 1'b1);
    look(3'd5, pc_c, "R8", 1'b1);
    look(3'd6, pc_c, "R8", 1'b1);
    look(3'd7, pc_c, "R8", 1'b1);

    // random mix against the bench model
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] rk;
      logic [PC_W-1:0] rp, rtp;
      logic [CYC_W-1:0] ra, ri, rt;
      bit rtv;
      string req;
      rk  = ($urandom_range(0, 1) == 0) ? 3'd0 : 3'($urandom_range(0, 7));
      rp  = {22'($urandom), 5'd0, 3'($urandom_range(0, 7)), 2'($urandom)};
      rtp = {22'($urandom), 5'd0, 3'($urandom_range(0, 7)), 2'($urandom)};
      rtv = ($urandom_range(0, 3) != 0);
      ra  = 16'($urandom);
      ri  = ($urandom_range(0, 9) == 0) ? 16'($urandom) : ra + 16'($urandom_range(0, 31));
      rt  = 16'($urandom_range(0, 31));
      case (rk)
        3'd0: req = "R5";
        3'd1, 3'd3, 3'd4: req = "R7";
        default: req = "R8";
      endcase
      step(rk, rp, rtv, rtp, ra, ri, rt, 1'b1, req, exp_fast(rk, rp));
    end

    done = 1;
    summary();
    $finish;
  end
endmodule